// File: doc/BRIEF.md
# Packed-Decimal Capable Add/Subtract Unit

This unit is the arithmetic core of an 8-bit accumulator ALU. It takes an accumulator byte, an operand byte, a carry input and a decimal-mode select. It returns one result byte together with carry, zero, negative and overflow flags. In binary mode it adds with carry or subtracts with borrow in two's complement. In decimal mode each byte holds two packed BCD digits. Each digit is corrected on its own, and the digit carry or borrow ripples from the low digit into the high digit.

The arithmetic is combinational. An output stage, chosen by parameter and present by default, captures the result and flags on a clock edge when the input strobe is high. It holds them while the strobe is low. The surrounding ALU decodes instructions, stores the status flags and writes the result back to the accumulator.

Top module: `dec_addsub_unit`

## Requirements
- R1: Binary add (`sub_sel`=0, `dec_mode`=0): `res` is the low 8 bits of A + M + C_in, and `c_out` is the ninth bit of that sum.
- R2: Binary subtract (`sub_sel`=1, `dec_mode`=0): `res` is A − M − (1 − C_in), computed as A + ~M + C_in. `c_out` is the ninth bit of A + ~M + C_in, so 1 means no borrow occurred.
- R3: `v_out` is 1 only when the result's bit 7 differs from A's bit 7 and the inputs agree in sign. For add, the condition is A[7] = M[7]. For subtract, it is A[7] ≠ M[7]. This rule applies in both modes, using the final result.
- R4: `z_out` is 1 exactly when `res` is zero, and `n_out` equals `res[7]`, in both modes.
- R5: Decimal add, low digit: L = A[3:0] + M[3:0] + C_in. If L ≥ 10, then L/10 (integer) passes to the high digit and the digit becomes L mod 10.
- R6: Decimal add, high digit: H = A[7:4] + M[7:4] + the low-digit carry. If H ≥ 10, the digit becomes H mod 10 and `c_out`=1. Otherwise the digit is H and `c_out`=0.
- R7: Decimal subtract, low digit: L = A[3:0] − M[3:0] − 1 + C_in. If L < 0, the digit becomes L + 10 and one is borrowed from the high digit. If L ≥ 10, the digit becomes L − 10 and one is added to the high digit.
- R8: Decimal subtract, high digit: H = A[7:4] − M[7:4] plus the low-digit carry or borrow. If H < 0, the digit becomes H + 10 and `c_out`=0. If H ≥ 10, the digit becomes H − 10 and `c_out`=1. Otherwise `c_out`=1.
- R9: With the output stage present, inputs applied while `in_valid`=1 appear on `res` and the flags after the next rising edge, and `out_valid` is 1 in that cycle.
- R10: While `in_valid`=0, `res` and all flags keep their values at each edge, and `out_valid` falls to 0.
- R11: A clock edge with `rst_n`=0 clears `res`, all flags and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the operands |
| sub_sel | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_mode | input | 1 | 1 = packed BCD arithmetic |
| acc_in | input | 8 | Accumulator operand A |
| opnd_in | input | 8 | Memory operand M |
| carry_in | input | 1 | Carry input C_in |
| res | output | 8 | Result byte |
| c_out | output | 1 | Carry out (no-borrow for subtract) |
| z_out | output | 1 | Result is zero |
| n_out | output | 1 | Result bit 7 |
| v_out | output | 1 | Signed overflow |
| out_valid | output | 1 | Result registered this cycle |

## Verification
A single operation can need digit correction and a carry-out at once. It can also set overflow and zero from the same corrected byte. The hardest case is a decimal carry or borrow out of the high digit while the low digit is also being corrected, as in 0x99 + 0x01 or 0x00 − 0x01. These cases are driven directly. Random valid-BCD operands then mix them with plain cases. Every captured result is compared in full, covering the byte and all four flags, against a digit-by-digit integer model. Each capture is followed by a cycle with the strobe low and new operands, which checks that the registered outputs hold.

// File: rtl/dau_pkg.sv
// Shared types for the decimal-capable add/subtract unit.
package dau_pkg;
    // Status flags produced with every result
    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } dau_flags_t;

    // Signed digit carry: -1 (borrow) up to +3
    typedef logic signed [2:0] dau_dcarry_t;
endpackage

// File: rtl/dau_digit_cell.sv
// One packed-BCD digit: adds or subtracts two 4-bit digits plus a signed
// incoming carry, then corrects the digit into range and emits a signed carry.
// Assumes valid BCD inputs; out-of-range digits are only truncated.
module dau_digit_cell
    import dau_pkg::*;
(
    input  logic [3:0]  a_dig,
    input  logic [3:0]  m_dig,
    input  logic        sub,
    input  dau_dcarry_t k_in,
    output logic [3:0]  dig_out,
    output dau_dcarry_t k_out
);
    logic signed [6:0] a_s, m_s, k_s, raw, corr;

    assign a_s = {3'b000, a_dig};
    assign m_s = {3'b000, m_dig};
    assign k_s = {{4{k_in[2]}}, k_in};

    // Raw signed digit value
    always_comb begin
        if (sub) raw = a_s - m_s + k_s;
        else     raw = a_s + m_s + k_s;
    end

    // Range correction and outgoing carry
    always_comb begin
        if (raw >= 7'sd30) begin
            k_out = 3'sd3;
            corr  = raw - 7'sd30;
        end else if (raw >= 7'sd20) begin
            k_out = 3'sd2;
            corr  = raw - 7'sd20;
        end else if (raw >= 7'sd10) begin
            k_out = 3'sd1;
            corr  = raw - 7'sd10;
        end else if (raw < 7'sd0) begin
            k_out = 3'b111;
            corr  = raw + 7'sd10;
        end else begin
            k_out = 3'sd0;
            corr  = raw;
        end
    end

    assign dig_out = corr[3:0];
endmodule

// File: rtl/dau_dec_path.sv
// Packed-decimal datapath: a ripple of digit cells. The low digit takes the
// carry input (as +C for add, C-1 for subtract); the top digit's carry sets
// the carry output. Assumes DATA_W is a multiple of four.
module dau_dec_path
    import dau_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    input  logic              sub,
    input  logic              cin,
    output logic [DATA_W-1:0] r,
    output logic              cout
);
    localparam int NDIG = DATA_W / 4;

    dau_dcarry_t kc [NDIG+1];

    // Initial digit carry from the carry input
    always_comb begin
        if (sub) kc[0] = cin ? 3'sd0 : 3'b111;
        else     kc[0] = cin ? 3'sd1 : 3'sd0;
    end

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        dau_digit_cell u_cell (
            .a_dig  (a[4*i +: 4]),
            .m_dig  (m[4*i +: 4]),
            .sub    (sub),
            .k_in   (kc[i]),
            .dig_out(r[4*i +: 4]),
            .k_out  (kc[i+1])
        );
    end

    // Add carries on a positive top carry; subtract carries unless it borrowed
    always_comb begin
        if (sub) cout = ~kc[NDIG][2];
        else     cout = ~kc[NDIG][2] & (kc[NDIG] != 3'sd0);
    end
endmodule

// File: rtl/dau_bin_path.sv
// Two's-complement datapath: A + M + C or A + ~M + C, carry is the extra bit.
module dau_bin_path #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    input  logic              sub,
    input  logic              cin,
    output logic [DATA_W-1:0] r,
    output logic              cout
);
    logic [DATA_W-1:0] m_eff;
    logic [DATA_W:0]   sum;

    // Operand inversion for subtract, then one wide adder
    always_comb begin
        m_eff = sub ? ~m : m;
        sum   = {1'b0, a} + {1'b0, m_eff} + {{DATA_W{1'b0}}, cin};
    end

    assign r    = sum[DATA_W-1:0];
    assign cout = sum[DATA_W];
endmodule

// File: rtl/dau_flag_gen.sv
// Builds zero, negative and overflow from the final result; passes carry.
module dau_flag_gen
    import dau_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] m,
    input  logic [DATA_W-1:0] r,
    input  logic              sub,
    input  logic              carry,
    output dau_flags_t        flags
);
    localparam int MSB = DATA_W - 1;

    // Flag derivation; subtract compares A against the inverted operand sign
    always_comb begin
        logic same_sign;
        same_sign = sub ? (a[MSB] != m[MSB]) : (a[MSB] == m[MSB]);
        flags.c   = carry;
        flags.z   = (r == '0);
        flags.n   = r[MSB];
        flags.v   = same_sign & (r[MSB] != a[MSB]);
    end
endmodule

// File: rtl/dec_addsub_unit.sv
// Top: selects the binary or decimal result, forms flags and optionally
// registers them under in_valid. Synchronous active-low reset.
module dec_addsub_unit
    import dau_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sub_sel,
    input  logic              dec_mode,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              z_out,
    output logic              n_out,
    output logic              v_out,
    output logic              out_valid
);
    logic [DATA_W-1:0] bin_r, dec_r, sel_r;
    logic              bin_c, dec_c, sel_c;
    dau_flags_t        nxt_flags;

    dau_bin_path #(.DATA_W(DATA_W)) u_bin (
        .a(acc_in), .m(opnd_in), .sub(sub_sel), .cin(carry_in),
        .r(bin_r), .cout(bin_c)
    );

    dau_dec_path #(.DATA_W(DATA_W)) u_dec (
        .a(acc_in), .m(opnd_in), .sub(sub_sel), .cin(carry_in),
        .r(dec_r), .cout(dec_c)
    );

    // Mode selection
    always_comb begin
        sel_r = dec_mode ? dec_r : bin_r;
        sel_c = dec_mode ? dec_c : bin_c;
    end

    dau_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .a(acc_in), .m(opnd_in), .r(sel_r), .sub(sub_sel), .carry(sel_c),
        .flags(nxt_flags)
    );

    if (OUT_REG) begin : g_reg
        logic [DATA_W-1:0] res_q;
        dau_flags_t        flg_q;
        logic              vld_q;

        // Output capture on strobe, hold otherwise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= '0;
                flg_q <= '0;
                vld_q <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    res_q <= sel_r;
                    flg_q <= nxt_flags;
                end
            end
        end

        assign res       = res_q;
        assign c_out     = flg_q.c;
        assign z_out     = flg_q.z;
        assign n_out     = flg_q.n;
        assign v_out     = flg_q.v;
        assign out_valid = vld_q;
    end else begin : g_comb
        assign res       = sel_r;
        assign c_out     = nxt_flags.c;
        assign z_out     = nxt_flags.z;
        assign n_out     = nxt_flags.n;
        assign v_out     = nxt_flags.v;
        assign out_valid = in_valid;
    end
endmodule

// File: rtl/dau_checker.sv
// Property checker for dec_addsub_unit, attached by bind below.
module dau_checker #(
    parameter int DATA_W  = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              sub_sel,
    input logic              dec_mode,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic              carry_in,
    input logic [DATA_W-1:0] res,
    input logic              c_out,
    input logic              z_out,
    input logic              n_out,
    input logic              v_out,
    input logic              out_valid
);
    localparam int MSB = DATA_W - 1;

    if (OUT_REG) begin : g_seq
        // R4: zero and negative track the registered result
        p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (z_out == (res == '0)));
        p_neg_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (n_out == res[MSB]));

        // R1: binary add matches the wide sum one cycle later
        p_bin_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !dec_mode && !sub_sel) |=>
            ({c_out, res} == ($past({1'b0, acc_in}) + $past({1'b0, opnd_in})
                              + {{DATA_W{1'b0}}, $past(carry_in)})));

        // R3: like-signed binary add whose sign flips reports overflow
        p_ovf_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !sub_sel && (acc_in[MSB] == opnd_in[MSB])) |=>
            (v_out == (res[MSB] != $past(acc_in[MSB]))));

        // R3: unlike-signed add can never overflow
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !sub_sel && (acc_in[MSB] != opnd_in[MSB])) |=> !v_out);

        // R9: strobe produces a valid output next cycle
        p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        // R10: no strobe, outputs held
        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(res) && $stable(c_out)
                           && $stable(z_out) && $stable(n_out) && $stable(v_out)));

        // R11: reset clears outputs
        p_reset_r11: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && res == '0 && !c_out && !z_out && !n_out && !v_out));
    end else begin : g_cmb
        // R4: combinational variant
        always_comb begin
            if (out_valid) begin
                a_zero_flag_r4: assert (z_out == (res == '0));
                a_neg_flag_r4:  assert (n_out == res[MSB]);
            end
        end
    end
endmodule

bind dec_addsub_unit dau_checker #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_dau_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_sel(sub_sel),
    .dec_mode(dec_mode), .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
    .res(res), .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out),
    .out_valid(out_valid)
);

// File: tb/dec_addsub_unit_test.sv
// Bench: directed corners plus seeded random operands, checked against
// an integer model of the requirements.
module dec_addsub_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       sub_sel = 1'b0;
    logic       dec_mode = 1'b0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic       carry_in = 1'b0;
    logic [7:0] res;
    logic       c_out, z_out, n_out, v_out, out_valid;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dec_addsub_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_sel(sub_sel),
        .dec_mode(dec_mode), .acc_in(acc_in), .opnd_in(opnd_in),
        .carry_in(carry_in), .res(res), .c_out(c_out), .z_out(z_out),
        .n_out(n_out), .v_out(v_out), .out_valid(out_valid)
    );

    // Digit-level reference: returns {v,n,z,c,res}
    function automatic logic [11:0] model(input bit sub, input bit dec,
                                          input logic [7:0] a, input logic [7:0] m,
                                          input bit cin);
        logic [7:0] r;
        bit c, v, same;
        if (!dec) begin
            logic [8:0] s;
            s = {1'b0, a} + {1'b0, (sub ? ~m : m)} + {8'd0, cin};
            r = s[7:0];
            c = s[8];
        end else begin
            int k, lo, hi;
            k = sub ? (cin ? 0 : -1) : (cin ? 1 : 0);
            lo = sub ? int'(a[3:0]) - int'(m[3:0]) + k : int'(a[3:0]) + int'(m[3:0]) + k;
            if (lo >= 10) begin k = lo / 10; lo = lo - 10 * k; end
            else if (lo < 0) begin k = -1; lo = lo + 10; end
            else k = 0;
            hi = sub ? int'(a[7:4]) - int'(m[7:4]) + k : int'(a[7:4]) + int'(m[7:4]) + k;
            if (hi >= 10) begin hi = hi % 10; c = 1'b1; end
            else if (hi < 0) begin hi = hi + 10; c = 1'b0; end
            else c = sub;
            r = {4'(hi), 4'(lo)};
        end
        same = sub ? (a[7] != m[7]) : (a[7] == m[7]);
        v = same && (r[7] != a[7]);
        return {v, r[7], (r == 8'd0), c, r};
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got {v,n,z,c,res}=%03h expected %03h", tag, act, exp);
        end
    endtask

    // Apply one strobed operation, check capture, then check hold with new inputs
    task automatic run_op(input bit sub, input bit dec, input logic [7:0] a,
                          input logic [7:0] m, input bit cin);
        logic [11:0] exp;
        string tag;
        exp = model(sub, dec, a, m, cin);
        if (!dec) tag = sub ? "R2/R3/R4 bin sub" : "R1/R3/R4 bin add";
        else      tag = sub ? "R7/R8/R3/R4 dec sub" : "R5/R6/R3/R4 dec add";
        @(negedge clk);
        sub_sel = sub; dec_mode = dec; acc_in = a; opnd_in = m; carry_in = cin;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, {v_out, n_out, z_out, c_out, res}, exp);
        check("R9 out_valid after strobe", {11'd0, out_valid}, 12'd1);
        acc_in = ~a; opnd_in = a ^ m; carry_in = ~cin; sub_sel = ~sub;
        @(negedge clk);
        check("R10 hold while strobe low", {v_out, n_out, z_out, c_out, res}, exp);
        check("R10 out_valid low", {11'd0, out_valid}, 12'd0);
    endtask

    function automatic logic [7:0] rnd_bcd();
        return {4'($urandom % 10), 4'($urandom % 10)};
    endfunction

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        // R11: outputs clear under reset
        check("R11 reset state", {v_out, n_out, z_out, c_out, res}, 12'd0);
        check("R11 reset valid", {11'd0, out_valid}, 12'd0);
        rst_n = 1'b1;

        // Directed corners
        run_op(0, 0, 8'h7F, 8'h01, 0);  // R3 positive overflow
        run_op(0, 0, 8'hFF, 8'h01, 0);  // R1 carry, R4 zero
        run_op(0, 0, 8'h80, 8'h80, 1);  // R3 negative overflow
        run_op(1, 0, 8'h00, 8'h01, 1);  // R2 borrow
        run_op(1, 0, 8'h80, 8'h01, 1);  // R3 subtract overflow
        run_op(1, 0, 8'h55, 8'h55, 1);  // R2 no borrow, zero
        run_op(0, 1, 8'h99, 8'h01, 0);  // R5/R6 double correction, carry out
        run_op(0, 1, 8'h45, 8'h38, 1);  // R5 low correction only
        run_op(0, 1, 8'h50, 8'h60, 0);  // R6 high correction only
        run_op(1, 1, 8'h40, 8'h01, 1);  // R7 low borrow
        run_op(1, 1, 8'h00, 8'h01, 1);  // R8 wrap, carry cleared
        run_op(1, 1, 8'h32, 8'h32, 0);  // R7/R8 borrow-in through both digits
        run_op(1, 1, 8'h99, 8'h00, 1);  // R8 no borrow

        // Random mix
        for (int i = 0; i < 400; i++) begin
            bit sub, dec, cin;
            logic [7:0] a, m;
            sub = 1'($urandom); dec = 1'($urandom); cin = 1'($urandom);
            if (dec) begin a = rnd_bcd(); m = rnd_bcd(); end
            else begin a = 8'($urandom); m = 8'($urandom); end
            run_op(sub, dec, a, m, cin);
        end

        // R11: reset mid-run clears captured state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset after activity", {v_out, n_out, z_out, c_out, res}, 12'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule